// File: doc/BRIEF.md
# SR-IOV Capability Register Block

This block holds the state of a single-root I/O virtualization capability for one physical function. Software reaches it through a dword-addressed register port with per-byte write enables. The block keeps the control word, the virtual-function count, and the page-size selection. It reports the fixed capability fields, which are initial and total VF counts, VF routing offset and stride, VF device ID, and the supported page sizes. It also drives one enable line per virtual function.

The enable lines form a contiguous prefix: VFs 0 through NumVFs-1 are on while the enable bit is set. The block keeps the enable bit consistent with the count. An enable request with a count larger than the total is refused, and any change to the count first switches every VF off.

Register map (dword offsets): 0 control (bit 0 VF enable, bit 3 VF memory-space enable, bit 4 ARI-capable hierarchy, upper half zero); 1 {TotalVFs[31:16], InitialVFs[15:0]}; 2 NumVFs[15:0]; 3 {stride[31:16], offset[15:0]}; 4 device ID[31:16]; 5 supported page sizes; 6 system page size; all other offsets read 0.

Top module: `sriov_cap_regs`

## Requirements
- R1: After reset the control word and NumVFs read 0, the system page size reads 0x00000001, every vf_enable line is low and active_vfs is 0.
- R2: In the control word only bits 0, 3 and 4 can be written, and only when byte enable 0 is set. Every other control bit reads 0.
- R3: NumVFs (offset 2, bits 15:0) is writable over all 16 bits, and each byte is updated only when its byte enable is set.
- R4: In the system page size (offset 6), exactly the bits of the supported set can be written, per byte enable. All other bits keep their value.
- R5: The supported page size field reads 0x553 OR-ed with the EXTRA_PGSIZE parameter.
- R6: Writing VF enable = 1 while NumVFs is greater than TOTAL_VFS leaves the enable bit reading 0 and all vf_enable lines low.
- R7: Writing VF enable = 1 with NumVFs at most TOTAL_VFS raises vf_enable[0..NumVFs-1] on the cycle after the write. No other line rises.
- R8: Writing the control byte with VF enable = 0 drops every vf_enable line on the next cycle.
- R9: Any write whose byte enables touch NumVFs clears the VF enable bit and drops every vf_enable line.
- R10: active_vfs equals NumVFs while the enable bit is set, and 0 otherwise.
- R11: InitialVFs, TotalVFs, VF offset, VF stride and VF device ID read their parameter values and ignore writes. Unmapped offsets read 0.
- R12: vf_mem_enable and ari_hier follow control bits 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_wr | input | 1 | write strobe |
| reg_addr | input | ADDR_W | dword offset for read and write |
| reg_be | input | 4 | byte enables for the write |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data at reg_addr (combinational) |
| vf_enable | output | TOTAL_VFS | per-VF enable |
| active_vfs | output | 16 | number of enabled VFs |
| vf_mem_enable | output | 1 | VF memory-space enable |
| ari_hier | output | 1 | ARI-capable hierarchy bit |

## Verification
A corrupted enable bit or count reaches vf_enable and active_vfs on the cycle after the write that caused it. The bench compares both against a behavioural model on every clock, so such an error is caught within one cycle. A fault in a stored field that drives no output, such as the page size or the upper byte of NumVFs, shows only on a read. For that reason each scenario reads the affected offset back right after the write.

// File: rtl/sriov_cap_regs.sv
module sriov_cap_regs #(
  parameter int          ADDR_W       = 3,
  parameter int          TOTAL_VFS    = 8,
  parameter int          INITIAL_VFS  = 8,
  parameter logic [15:0] VF_OFFSET    = 16'd1,
  parameter logic [15:0] VF_STRIDE    = 16'd1,
  parameter logic [15:0] VF_DEV_ID    = 16'h10CA,
  parameter logic [31:0] EXTRA_PGSIZE = 32'h0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [3:0]           reg_be,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [TOTAL_VFS-1:0] vf_enable,
  output logic [15:0]          active_vfs,
  output logic                 vf_mem_enable,
  output logic                 ari_hier
);
  localparam logic [15:0] CTRL_WMASK = 16'h0019;
  localparam logic [31:0] SUP_PGSIZE = 32'h0000_0553 | EXTRA_PGSIZE;
  localparam logic [15:0] TOTAL_W    = 16'(TOTAL_VFS);
  localparam logic [15:0] INIT_W     = 16'(INITIAL_VFS);

  logic [15:0] ctrl_q, num_q, ctrl_d;
  logic [31:0] sys_q;
  logic [31:0] bmask;

  assign bmask = {{8{reg_be[3]}}, {8{reg_be[2]}}, {8{reg_be[1]}}, {8{reg_be[0]}}};

  wire wr_ctrl = reg_wr && reg_addr == ADDR_W'(0) && reg_be[0];
  wire wr_num  = reg_wr && reg_addr == ADDR_W'(2) && (reg_be[0] || reg_be[1]);
  wire wr_sys  = reg_wr && reg_addr == ADDR_W'(6);

  always_comb begin
    ctrl_d = reg_wdata[15:0] & CTRL_WMASK;
    if (ctrl_d[0] && num_q > TOTAL_W) ctrl_d[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      num_q  <= '0;
      sys_q  <= 32'h1;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_num) begin
        ctrl_q[0] <= 1'b0;
        num_q     <= (num_q & ~bmask[15:0]) | (reg_wdata[15:0] & bmask[15:0]);
      end
      if (wr_sys) sys_q <= (sys_q & ~(SUP_PGSIZE & bmask)) | (reg_wdata & SUP_PGSIZE & bmask);
    end
  end

  for (genvar i = 0; i < TOTAL_VFS; i++) begin : g_vf
    assign vf_enable[i] = ctrl_q[0] && (num_q > 16'(i));
  end

  assign active_vfs    = ctrl_q[0] ? num_q : 16'h0;
  assign vf_mem_enable = ctrl_q[3];
  assign ari_hier      = ctrl_q[4];

  always_comb begin
    case (reg_addr)
      ADDR_W'(0): reg_rdata = {16'h0, ctrl_q};
      ADDR_W'(1): reg_rdata = {TOTAL_W, INIT_W};
      ADDR_W'(2): reg_rdata = {16'h0, num_q};
      ADDR_W'(3): reg_rdata = {VF_STRIDE, VF_OFFSET};
      ADDR_W'(4): reg_rdata = {VF_DEV_ID, 16'h0};
      ADDR_W'(5): reg_rdata = SUP_PGSIZE;
      ADDR_W'(6): reg_rdata = sys_q;
      default:    reg_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/sriov_cap_regs_chk.sv
module sriov_cap_regs_chk #(
  parameter int ADDR_W    = 3,
  parameter int TOTAL_VFS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [3:0]           reg_be,
  input logic [31:0]          reg_wdata,
  input logic [TOTAL_VFS-1:0] vf_enable,
  input logic [15:0]          active_vfs
);
  AST_NUMWR_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(2) && (reg_be[0] || reg_be[1])) |=> (vf_enable == '0 && active_vfs == 16'h0)); // R9
  AST_CTRL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(0) && reg_be[0] && !reg_wdata[0]) |=> vf_enable == '0); // R8
  AST_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    (vf_enable & (vf_enable + 1'b1)) == '0); // R7
  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vf_enable) == 32'(active_vfs)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    active_vfs <= 16'(TOTAL_VFS)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(vf_enable)); // R7
endmodule

bind sriov_cap_regs sriov_cap_regs_chk #(.ADDR_W(ADDR_W), .TOTAL_VFS(TOTAL_VFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
  .reg_wdata(reg_wdata), .vf_enable(vf_enable), .active_vfs(active_vfs));

// File: tb/sriov_cap_regs_test.sv
`timescale 1ns/1ps
module sriov_cap_regs_test;
  localparam int          TV    = 8;
  localparam int          INIT  = 4;
  localparam logic [15:0] OFS   = 16'd2;
  localparam logic [15:0] STR   = 16'd1;
  localparam logic [15:0] DID   = 16'hBEEF;
  localparam logic [31:0] EXTRA = 32'h0000_0008;
  localparam logic [31:0] SUP   = 32'h0000_0553 | EXTRA;

  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [2:0] reg_addr = '0;
  logic [3:0] reg_be = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [TV-1:0] vf_enable;
  logic [15:0] active_vfs;
  logic vf_mem_enable, ari_hier;

  always #2.5 clk = ~clk;

  sriov_cap_regs #(.ADDR_W(3), .TOTAL_VFS(TV), .INITIAL_VFS(INIT), .VF_OFFSET(OFS),
    .VF_STRIDE(STR), .VF_DEV_ID(DID), .EXTRA_PGSIZE(EXTRA)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vf_enable(vf_enable),
    .active_vfs(active_vfs), .vf_mem_enable(vf_mem_enable), .ari_hier(ari_hier));

  logic [15:0] m_ctrl = '0, m_num = '0;
  logic [31:0] m_sys = 32'h1;
  int errs = 0, checks = 0;
  bit live = 0, done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {16'h0, m_ctrl};
      3'd1: return {16'(TV), 16'(INIT)};
      3'd2: return {16'h0, m_num};
      3'd3: return {STR, OFS};
      3'd4: return {DID, 16'h0};
      3'd5: return SUP;
      3'd6: return m_sys;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [TV-1:0] exp_en();
    logic [TV-1:0] e = '0;
    for (int i = 0; i < TV; i++) e[i] = m_ctrl[0] && (int'(m_num) > i);
    return e;
  endfunction

  task automatic model_wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] bm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    logic [15:0] c;
    if (a == 3'd0 && be[0]) begin
      c = {8'h0, d[7:0] & 8'h19};
      if (c[0] && int'(m_num) > TV) c[0] = 1'b0;
      m_ctrl = c;
    end
    if (a == 3'd2 && (be[0] || be[1])) begin
      if (be[0]) m_num[7:0] = d[7:0];
      if (be[1]) m_num[15:8] = d[15:8];
      m_ctrl[0] = 1'b0;
    end
    if (a == 3'd6) m_sys = (m_sys & ~(SUP & bm)) | (d & SUP & bm);
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_be = be; reg_wdata = d; reg_wr = 1;
    @(posedge clk);
    #1;
    model_wr(a, be, d);
    reg_wr = 0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp_read(a));
  endtask

  always @(negedge clk) if (live) begin
    chk("R6 R7 R8 R9 vf_enable", 32'(vf_enable), 32'(exp_en()));
    chk("R10 active_vfs", 32'(active_vfs), m_ctrl[0] ? 32'(m_num) : 32'h0);
    chk("R12 mem_enable/ari", {30'h0, ari_hier, vf_mem_enable}, {30'h0, m_ctrl[4], m_ctrl[3]});
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1; live = 1;
    // R1 reset state
    rd("R1 ctrl", 3'd0); rd("R1 numvfs", 3'd2); rd("R1 syspg", 3'd6);
    chk("R1 vf_enable", 32'(vf_enable), 32'h0);
    // R5 R11 fixed fields and unmapped
    rd("R5 supported", 3'd5);
    for (int a = 0; a < 8; a++) if (a == 1 || a == 3 || a == 4 || a == 5 || a == 7) wr(3'(a), 4'hF, 32'hFFFF_FFFF);
    rd("R11 counts", 3'd1); rd("R11 ofs/stride", 3'd3); rd("R11 devid", 3'd4);
    rd("R5 supported after write", 3'd5); rd("R11 unmapped", 3'd7);
    // R2 control write mask and byte enables
    wr(3'd0, 4'hE, 32'hFFFF_FFFF); rd("R2 ctrl byte0 disabled", 3'd0);
    wr(3'd0, 4'hF, 32'hFFFF_FFFF); rd("R2 ctrl mask", 3'd0);
    // R3 R9 NumVFs writes clear enable
    wr(3'd2, 4'h1, 32'hFFFF_FF05); rd("R3 R9 numvfs low", 3'd2); rd("R9 ctrl after num", 3'd0);
    // R7 legal enable
    wr(3'd0, 4'h1, 32'h0000_0019); rd("R7 ctrl", 3'd0);
    repeat (3) @(negedge clk);
    // R8 disable
    wr(3'd0, 4'h1, 32'h0000_0018); rd("R8 ctrl", 3'd0);
    // R7 boundary: NumVFs == TOTAL
    wr(3'd2, 4'h3, 32'h0000_0008);
    wr(3'd0, 4'h1, 32'h0000_0001); rd("R7 full enable", 3'd0);
    // R9 upper byte write while enabled
    wr(3'd2, 4'h2, 32'h0000_0100); rd("R3 R9 numvfs high", 3'd2); rd("R9 ctrl cleared", 3'd0);
    // R6 overflow refused
    wr(3'd0, 4'h1, 32'h0000_0001); rd("R6 ctrl refused", 3'd0);
    wr(3'd2, 4'h3, 32'h0000_0009);
    wr(3'd0, 4'h1, 32'h0000_0011); rd("R6 ctrl refused 9", 3'd0);
    // R9 write not touching NumVFs bytes
    wr(3'd2, 4'h3, 32'h0000_0003); wr(3'd0, 4'h1, 32'h1);
    wr(3'd2, 4'hC, 32'hFFFF_FFFF); rd("R9 upper bytes ignored", 3'd2); rd("R9 ctrl kept", 3'd0);
    wr(3'd2, 4'h3, 32'h0000_0000); wr(3'd0, 4'h1, 32'h1); rd("R7 zero vfs", 3'd0);
    // R4 system page size
    wr(3'd6, 4'hF, 32'hFFFF_FFFF); rd("R4 syspg all", 3'd6);
    wr(3'd6, 4'h1, 32'h0000_0000); rd("R4 syspg byte0", 3'd6);
    wr(3'd6, 4'hF, 32'h0000_0008); rd("R4 syspg extra bit", 3'd6);
    wr(3'd6, 4'hF, 32'h0000_0004); rd("R4 syspg unsupported", 3'd6);
    // R1 reset again mid-operation
    wr(3'd2, 4'h3, 32'h2); wr(3'd0, 4'h1, 32'h19);
    @(negedge clk); rst_n = 0; live = 0;
    @(posedge clk); #1; m_ctrl = '0; m_num = '0; m_sys = 32'h1;
    @(negedge clk); rst_n = 1; live = 1;
    rd("R1 ctrl after reset", 3'd0); rd("R1 syspg after reset", 3'd6); rd("R1 num after reset", 3'd2);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule